// File: doc/BRIEF.md
# Reference Clock Source Selector

This block chooses which of a small set of candidate timing references a node should trace. Each candidate brings a validity flag, a priority (a smaller number is preferred), a 4-bit quality level and a clock identity. From these the selector decides which candidates are usable, ranks them and registers its choice. When nothing is usable it raises a holdover flag. It also produces the quality level to advertise downstream.

The ranking depends on configuration. With quality control off, only priority counts. With it on, quality level counts first and priority breaks ties. An optional identity check rejects any candidate that carries the node's own clock identity, which prevents timing loops. A candidate whose quality code is unrecognised can be admitted through a configurable remap. A per-input frequency-fault flag removes a candidate until software pulses its recover line.

Software commands move the selector between three modes: automatic, manual (preferred target) and forced (target taken unconditionally). In automatic operation the selector can either revert to the best source or stay on the current one. All outputs are registered. They reflect the inputs, the mode and the fault flags as held just before the active clock edge. A command or a fault pulse therefore shows at the outputs two edges later.

Top module: `refsel_top`

## Requirements
- R1: After reset the mode is automatic, `selIdx` is 0, `holdover` is 1 and `outSsm` is 4'hF.
- R2: With `ssmCtrlEn` low, the eligible source with the numerically smallest priority is chosen, and equal priorities go to the lowest index.
- R3: With `ssmCtrlEn` high, sources rank by quality in the order 4'h2 (best), 4'h4, 4'h8, 4'hB, then by priority, then by lowest index. A source at level 4'hF is not eligible.
- R4: Any quality code other than 2, 4, 8, B or F is unknown, and an unknown source is never eligible. If `unkMapEn` is set and `unkMapLvl` is one of the five known codes, unknown sources are treated as carrying `unkMapLvl`.
- R5: With `clkIdCtrlEn` high, a source whose clock identity equals `localClkId` is not eligible.
- R6: A pulse on `srcFreqBad[i]` makes source i ineligible until a pulse on `freqRecover[i]`. When both pulse together, the fault wins.
- R7: In revertive operation the selector always tracks the best eligible source and returns to it once it recovers.
- R8: In non-revertive operation the current source is kept while it stays eligible. The best source is taken only when the current one is lost or the selector leaves holdover.
- R9: When no source can be chosen outside forced mode, `holdover` is 1 and `selIdx` keeps its last value. Outside forced mode a chosen source is always eligible.
- R10: A command with `cmdOp`=1 selects manual mode on `cmdSrc`. The target is chosen while it is eligible; otherwise automatic selection applies.
- R11: A command with `cmdOp`=2 forces `cmdSrc` whatever its status, with `holdover` low.
- R12: A command with `cmdOp`=0 returns to automatic mode. A command with `cmdOp`=3 has no effect.
- R13: `outSsm` is the effective level of the chosen source, with unknown levels sent as 4'hF and 4'hF sent in holdover. When `maxOutEn` is set with a known `maxOutLvl`, a better level is replaced by `maxOutLvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | N | Candidate qualified as present |
| srcFreqBad | input | N | Frequency-fault set pulse per candidate |
| freqRecover | input | N | Frequency-fault clear pulse per candidate |
| srcPri | input | N*PRI_W | Priorities, candidate i at bits [i*PRI_W +: PRI_W] |
| srcSsm | input | N*4 | Quality codes, candidate i at bits [i*4 +: 4] |
| srcClkId | input | N*ID_W | Clock identities, candidate i at bits [i*ID_W +: ID_W] |
| localClkId | input | ID_W | This node's own clock identity |
| ssmCtrlEn | input | 1 | Quality level takes part in ranking |
| clkIdCtrlEn | input | 1 | Loop rejection by clock identity |
| revertive | input | 1 | 1 revertive, 0 non-revertive |
| unkMapEn | input | 1 | Enable remap of unknown quality |
| unkMapLvl | input | 4 | Level given to unknown sources |
| maxOutEn | input | 1 | Enable clamp of advertised level |
| maxOutLvl | input | 4 | Best level that may be advertised |
| cmdValid | input | 1 | Mode command strobe |
| cmdOp | input | 2 | 0 auto, 1 manual, 2 forced, 3 none |
| cmdSrc | input | $clog2(N) | Target of manual or forced command |
| selIdx | output | $clog2(N) | Traced source index |
| holdover | output | 1 | No source chosen |
| outSsm | output | 4 | Quality level sent downstream |

## Verification
The assertions check, on every cycle, that holdover advertises 4'hF and that a known clamp level is never beaten. They also check that forced mode follows its target, and that any other selection is a source that was valid and, with loop rejection on, does not carry the local identity. The ranking orders, the unknown-level remap, the life of the frequency-fault flag and the history-dependent difference between revertive and non-revertive switching can only be shown by the bench's sweeps. The bench compares each sweep step against a model that keeps its own selection history.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO   = 2'd0,
    MODE_MANUAL = 2'd1,
    MODE_FORCED = 2'd2
  } selMode_e;

  localparam logic [3:0] SSM_PRC  = 4'h2;
  localparam logic [3:0] SSM_SSUA = 4'h4;
  localparam logic [3:0] SSM_SSUB = 4'h8;
  localparam logic [3:0] SSM_SEC  = 4'hB;
  localparam logic [3:0] SSM_DNU  = 4'hF;

  localparam logic [2:0] RANK_UNK = 3'd5;
  localparam logic [2:0] RANK_DNU = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic holdNext;
  } selStrb_t;

  // quality rank: 0 is best, 5 is unknown
  function automatic logic [2:0] ssmRank(input logic [3:0] code);
    case (code)
      SSM_PRC:  return 3'd0;
      SSM_SSUA: return 3'd1;
      SSM_SSUB: return 3'd2;
      SSM_SEC:  return 3'd3;
      SSM_DNU:  return RANK_DNU;
      default:  return RANK_UNK;
    endcase
  endfunction

endpackage

// File: rtl/refsel_dp.sv
module refsel_dp
  import refsel_pkg::*;
#(
  parameter int N     = 4,
  parameter int PRI_W = 4,
  parameter int ID_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         srcValid,
  input  logic [N-1:0]         srcFreqBad,
  input  logic [N-1:0]         freqRecover,
  input  logic [N*PRI_W-1:0]   srcPri,
  input  logic [N*4-1:0]       srcSsm,
  input  logic [N*ID_W-1:0]    srcClkId,
  input  logic [ID_W-1:0]      localClkId,
  input  logic                 ssmCtrlEn,
  input  logic                 clkIdCtrlEn,
  input  logic                 unkMapEn,
  input  logic [3:0]           unkMapLvl,
  input  logic                 maxOutEn,
  input  logic [3:0]           maxOutLvl,
  input  selStrb_t             strb,
  input  logic [$clog2(N)-1:0] nextSel,
  output logic [N-1:0]         elig,
  output logic [$clog2(N)-1:0] bestIdx,
  output logic                 bestFound,
  output logic [3:0]           outSsm
);
  localparam int IDX_W = $clog2(N);
  localparam int KEY_W = PRI_W + 3;

  logic [N-1:0]     freqFlagQ;
  logic [3:0]       effLvl [N];
  logic [2:0]       rankI  [N];
  logic [KEY_W-1:0] key    [N];
  logic [KEY_W-1:0] bestKey;
  logic [3:0]       sendLvl;
  logic             mapOk;

  assign mapOk = unkMapEn && (ssmRank(unkMapLvl) != RANK_UNK);

  // frequency-fault flags: set wins over recover
  always_ff @(posedge clk) begin
    if (!rstN) freqFlagQ <= '0;
    else       freqFlagQ <= (freqFlagQ & ~freqRecover) | srcFreqBad;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [3:0] rawLvl;
    assign rawLvl   = srcSsm[i*4 +: 4];
    assign effLvl[i] = (ssmRank(rawLvl) == RANK_UNK && mapOk) ? unkMapLvl : rawLvl;
    assign rankI[i]  = ssmRank(effLvl[i]);
    assign elig[i]   = srcValid[i] & ~freqFlagQ[i]
                     & (rankI[i] != RANK_UNK)
                     & ~(ssmCtrlEn & (rankI[i] == RANK_DNU))
                     & ~(clkIdCtrlEn & (srcClkId[i*ID_W +: ID_W] == localClkId));
    assign key[i]    = {(ssmCtrlEn ? rankI[i] : 3'd0), srcPri[i*PRI_W +: PRI_W]};
  end

  // lowest key wins; strict compare keeps the lowest index on ties
  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestKey   = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!bestFound || key[i] < bestKey)) begin
        bestFound = 1'b1;
        bestIdx   = IDX_W'(i);
        bestKey   = key[i];
      end
    end
  end

  always_comb begin
    sendLvl = effLvl[nextSel];
    if (ssmRank(sendLvl) == RANK_UNK) sendLvl = SSM_DNU;
    if (maxOutEn && ssmRank(maxOutLvl) != RANK_UNK &&
        ssmRank(sendLvl) < ssmRank(maxOutLvl))
      sendLvl = maxOutLvl;
    if (strb.holdNext) sendLvl = SSM_DNU;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outSsm <= SSM_DNU;
    else       outSsm <= sendLvl;
  end

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [$clog2(N)-1:0] cmdSrc,
  input  logic                 revertive,
  input  logic [N-1:0]         elig,
  input  logic [$clog2(N)-1:0] bestIdx,
  input  logic                 bestFound,
  output selStrb_t             strb,
  output logic [$clog2(N)-1:0] nextSel,
  output logic [$clog2(N)-1:0] selIdx,
  output logic                 holdover
);
  localparam int IDX_W = $clog2(N);

  selMode_e         modeQ;
  logic [IDX_W-1:0] tgtQ;
  logic             nextHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_AUTO;
      tgtQ  <= '0;
    end else if (cmdValid) begin
      case (cmdOp)
        2'd0: modeQ <= MODE_AUTO;
        2'd1: begin modeQ <= MODE_MANUAL; tgtQ <= cmdSrc; end
        2'd2: begin modeQ <= MODE_FORCED; tgtQ <= cmdSrc; end
        default: ;
      endcase
    end
  end

  always_comb begin
    nextSel  = selIdx;
    nextHold = holdover;
    if (modeQ == MODE_FORCED) begin
      nextSel  = tgtQ;
      nextHold = 1'b0;
    end else if (modeQ == MODE_MANUAL && elig[tgtQ]) begin
      nextSel  = tgtQ;
      nextHold = 1'b0;
    end else if (!revertive && !holdover && elig[selIdx]) begin
      nextHold = 1'b0;
    end else if (bestFound) begin
      nextSel  = bestIdx;
      nextHold = 1'b0;
    end else begin
      nextHold = 1'b1;
    end
  end

  assign strb.holdNext = nextHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx   <= '0;
      holdover <= 1'b1;
    end else begin
      selIdx   <= nextSel;
      holdover <= nextHold;
    end
  end

endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int N     = 4,
  parameter int PRI_W = 4,
  parameter int ID_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         srcValid,
  input  logic [N-1:0]         srcFreqBad,
  input  logic [N-1:0]         freqRecover,
  input  logic [N*PRI_W-1:0]   srcPri,
  input  logic [N*4-1:0]       srcSsm,
  input  logic [N*ID_W-1:0]    srcClkId,
  input  logic [ID_W-1:0]      localClkId,
  input  logic                 ssmCtrlEn,
  input  logic                 clkIdCtrlEn,
  input  logic                 revertive,
  input  logic                 unkMapEn,
  input  logic [3:0]           unkMapLvl,
  input  logic                 maxOutEn,
  input  logic [3:0]           maxOutLvl,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [$clog2(N)-1:0] cmdSrc,
  output logic [$clog2(N)-1:0] selIdx,
  output logic                 holdover,
  output logic [3:0]           outSsm
);
  localparam int IDX_W = $clog2(N);

  selStrb_t         strb;
  logic [IDX_W-1:0] nextSel;
  logic [IDX_W-1:0] bestIdx;
  logic             bestFound;
  logic [N-1:0]     elig;

  refsel_dp #(.N(N), .PRI_W(PRI_W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .srcValid(srcValid), .srcFreqBad(srcFreqBad), .freqRecover(freqRecover),
    .srcPri(srcPri), .srcSsm(srcSsm), .srcClkId(srcClkId), .localClkId(localClkId),
    .ssmCtrlEn(ssmCtrlEn), .clkIdCtrlEn(clkIdCtrlEn),
    .unkMapEn(unkMapEn), .unkMapLvl(unkMapLvl),
    .maxOutEn(maxOutEn), .maxOutLvl(maxOutLvl),
    .strb(strb), .nextSel(nextSel),
    .elig(elig), .bestIdx(bestIdx), .bestFound(bestFound), .outSsm(outSsm)
  );

  refsel_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSrc(cmdSrc), .revertive(revertive),
    .elig(elig), .bestIdx(bestIdx), .bestFound(bestFound),
    .strb(strb), .nextSel(nextSel), .selIdx(selIdx), .holdover(holdover)
  );

endmodule

// File: rtl/refsel_chk.sv
module refsel_chk
  import refsel_pkg::*;
#(
  parameter int N    = 4,
  parameter int ID_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [N-1:0]         srcValid,
  input logic [N*ID_W-1:0]    srcClkId,
  input logic [ID_W-1:0]      localClkId,
  input logic                 clkIdCtrlEn,
  input logic                 maxOutEn,
  input logic [3:0]           maxOutLvl,
  input logic [$clog2(N)-1:0] selIdx,
  input logic                 holdover,
  input logic [3:0]           outSsm,
  input selMode_e             modeQ,
  input logic [$clog2(N)-1:0] tgtQ
);
  logic [N-1:0]      prevValid;
  logic [N*ID_W-1:0] prevIds;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= '0;
      prevIds   <= '0;
    end else begin
      prevValid <= srcValid;
      prevIds   <= srcClkId;
    end
  end

  AST_HOLD_SENDS_DNU: assert property (@(posedge clk) disable iff (!rstN)
    holdover |-> outSsm == SSM_DNU); // R13

  AST_CLAMP_RESPECTED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maxOutEn) && ssmRank($past(maxOutLvl)) != RANK_UNK && !holdover)
      |-> ssmRank(outSsm) >= ssmRank($past(maxOutLvl))); // R13

  AST_FORCED_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeQ) == MODE_FORCED) |-> (!holdover && selIdx == $past(tgtQ))); // R11

  AST_SEL_WAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeQ) != MODE_FORCED && !holdover) |-> prevValid[selIdx]); // R9

  AST_NO_OWN_ID: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clkIdCtrlEn) && $past(modeQ) != MODE_FORCED && !holdover)
      |-> prevIds[selIdx*ID_W +: ID_W] != $past(localClkId)); // R5

endmodule

bind refsel_top refsel_chk #(.N(N), .ID_W(ID_W)) i_chk (
  .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcClkId(srcClkId),
  .localClkId(localClkId), .clkIdCtrlEn(clkIdCtrlEn),
  .maxOutEn(maxOutEn), .maxOutLvl(maxOutLvl),
  .selIdx(selIdx), .holdover(holdover), .outSsm(outSsm),
  .modeQ(u_ctrl.modeQ), .tgtQ(u_ctrl.tgtQ)
);

// File: tb/test_refsel_top.sv
`timescale 1ns/1ps
module test_refsel_top;
  localparam int N = 4;
  localparam int PRI_W = 4;
  localparam int ID_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] srcValid = '0, srcFreqBad = '0, freqRecover = '0;
  logic [N*PRI_W-1:0] srcPri = '0;
  logic [N*4-1:0] srcSsm = '0;
  logic [N*ID_W-1:0] srcClkId = '0;
  logic [ID_W-1:0] localClkId = '0;
  logic ssmCtrlEn = 0, clkIdCtrlEn = 0, revertive = 1, unkMapEn = 0, maxOutEn = 0;
  logic [3:0] unkMapLvl = 4'h0, maxOutLvl = 4'h0;
  logic cmdValid = 0;
  logic [1:0] cmdOp = 0;
  logic [1:0] cmdSrc = 0;
  logic [1:0] selIdx;
  logic holdover;
  logic [3:0] outSsm;

  int checks = 0, errors = 0;
  int expSel = 0, mMode = 0, mTgt = 0;
  bit expHold = 1;
  logic [3:0] expSsm = 4'hF;
  logic [N-1:0] mFlag = '0;
  logic [3:0] codes [6] = '{4'h2, 4'h4, 4'h8, 4'hB, 4'hF, 4'h0};

  always #2 clk = ~clk;

  refsel_top #(.N(N), .PRI_W(PRI_W), .ID_W(ID_W)) i_refsel_top (.*);

  function automatic int qr(input logic [3:0] c);
    case (c)
      4'h2: return 0; 4'h4: return 1; 4'h8: return 2;
      4'hB: return 3; 4'hF: return 4; default: return 5;
    endcase
  endfunction

  function automatic logic [3:0] effOf(input int i);
    logic [3:0] c = srcSsm[i*4 +: 4];
    if (qr(c) == 5 && unkMapEn && qr(unkMapLvl) < 5) return unkMapLvl;
    return c;
  endfunction

  function automatic bit eligOf(input int i);
    if (!srcValid[i] || mFlag[i]) return 0;
    if (qr(effOf(i)) == 5) return 0;
    if (ssmCtrlEn && qr(effOf(i)) == 4) return 0;
    if (clkIdCtrlEn && srcClkId[i*ID_W +: ID_W] == localClkId) return 0;
    return 1;
  endfunction

  function automatic int bestOf();
    int b = -1, bk = 0;
    for (int i = 0; i < N; i++) begin
      int k = (ssmCtrlEn ? qr(effOf(i)) * 256 : 0) + int'(srcPri[i*PRI_W +: PRI_W]);
      if (eligOf(i) && (b < 0 || k < bk)) begin b = i; bk = k; end
    end
    return b;
  endfunction

  task automatic modelStep();
    int b = bestOf();
    logic [3:0] l;
    if (mMode == 2) begin expSel = mTgt; expHold = 0; end
    else if (mMode == 1 && eligOf(mTgt)) begin expSel = mTgt; expHold = 0; end
    else if (!revertive && !expHold && eligOf(expSel)) expHold = 0;
    else if (b >= 0) begin expSel = b; expHold = 0; end
    else expHold = 1;
    l = effOf(expSel);
    if (qr(l) == 5) l = 4'hF;
    if (maxOutEn && qr(maxOutLvl) < 5 && qr(l) < qr(maxOutLvl)) l = maxOutLvl;
    if (expHold) l = 4'hF;
    expSsm = l;
  endtask

  task automatic settle(input string tag);
    repeat (3) @(posedge clk);
    @(negedge clk);
    modelStep();
    checks++;
    if (int'(selIdx) != expSel || holdover !== expHold || outSsm !== expSsm) begin
      errors++;
      $display("FAIL %s: sel=%0d hold=%0b ssm=%h expected sel=%0d hold=%0b ssm=%h",
               tag, selIdx, holdover, outSsm, expSel, expHold, expSsm);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int src);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdSrc = 2'(src);
    @(posedge clk); @(negedge clk);
    cmdValid = 0;
    case (op)
      2'd0: mMode = 0;
      2'd1: begin mMode = 1; mTgt = src; end
      2'd2: begin mMode = 2; mTgt = src; end
      default: ;
    endcase
  endtask

  task automatic pulse(input logic [N-1:0] bad, input logic [N-1:0] rec);
    @(negedge clk);
    srcFreqBad = bad; freqRecover = rec;
    @(posedge clk); @(negedge clk);
    srcFreqBad = '0; freqRecover = '0;
    mFlag = (mFlag & ~rec) | bad;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (selIdx !== 0 || holdover !== 1 || outSsm !== 4'hF) begin
      errors++;
      $display("FAIL R1: sel=%0d hold=%0b ssm=%h expected sel=0 hold=1 ssm=f", selIdx, holdover, outSsm);
    end
    rstN = 1;
    srcSsm = {4'hB, 4'hB, 4'hB, 4'hB};
    settle("R1");

    // R2: priority-only sweep, all valid
    srcValid = '1;
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < N; i++) srcPri[i*PRI_W +: PRI_W] = PRI_W'((v >> (2*i)) & 3);
      settle("R2");
    end

    // R3: quality sweep with fixed priorities
    ssmCtrlEn = 1;
    srcPri = {4'd1, 4'd2, 4'd1, 4'd3};
    for (int v = 0; v < 1296; v++) begin
      int r = v;
      for (int i = 0; i < N; i++) begin srcSsm[i*4 +: 4] = codes[r % 6]; r = r / 6; end
      settle("R3");
    end

    // R4: unknown remap
    unkMapEn = 1;
    for (int m = 0; m < 6; m++) begin
      unkMapLvl = codes[m];
      for (int v = 0; v < 256; v++) begin
        for (int i = 0; i < N; i++) begin
          case ((v >> (2*i)) & 3)
            0: srcSsm[i*4 +: 4] = 4'h0;
            1: srcSsm[i*4 +: 4] = 4'h4;
            2: srcSsm[i*4 +: 4] = 4'hB;
            default: srcSsm[i*4 +: 4] = 4'h6;
          endcase
        end
        settle("R4");
      end
    end
    unkMapEn = 0;

    // R5: clock identity loop rejection
    srcSsm = {4'h2, 4'h2, 4'h2, 4'h2};
    srcPri = {4'd3, 4'd2, 4'd1, 4'd0};
    localClkId = 8'h5;
    for (int e = 0; e < 2; e++) begin
      clkIdCtrlEn = e[0];
      for (int v = 0; v < 16; v++) begin
        for (int i = 0; i < N; i++) srcClkId[i*ID_W +: ID_W] = v[i] ? 8'h5 : 8'h7;
        settle("R5");
      end
    end
    clkIdCtrlEn = 0;

    // R6: frequency fault lifetime
    settle("R6");
    pulse(4'b0001, 4'b0000); settle("R6");
    srcValid = 4'b0111; settle("R6");
    srcValid = 4'b1111; settle("R6");
    pulse(4'b0001, 4'b0001); settle("R6");
    pulse(4'b0000, 4'b0001); settle("R6");
    pulse(4'b1111, 4'b0000); settle("R9");
    pulse(4'b0000, 4'b1111); settle("R6");

    // R7 / R8: valid-mask transitions in both switching modes
    for (int rv = 0; rv < 2; rv++) begin
      revertive = rv[0];
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          srcValid = 4'(a); settle(rv ? "R7" : "R8");
          srcValid = 4'(b); settle(rv ? "R7" : "R8");
        end
    end
    revertive = 1;

    // R10: manual mode per target over masks
    for (int t = 0; t < N; t++) begin
      cmd(2'd1, t);
      for (int v = 0; v < 16; v++) begin srcValid = 4'(v); settle("R10"); end
    end

    // R11: forced mode even on invalid targets
    for (int t = 0; t < N; t++) begin
      cmd(2'd2, t);
      for (int v = 0; v < 16; v += 5) begin srcValid = 4'(v); settle("R11"); end
    end

    // R12: op 3 ignored, op 0 clears
    srcValid = '1;
    cmd(2'd1, 2); settle("R12");
    cmd(2'd3, 1); settle("R12");
    cmd(2'd0, 0); settle("R12");

    // R13: advertised level and clamp
    ssmCtrlEn = 0;
    srcValid = 4'b0001;
    for (int e = 0; e < 2; e++) begin
      maxOutEn = e[0];
      for (int m = 0; m < 6; m++) begin
        maxOutLvl = codes[m];
        for (int s = 0; s < 6; s++) begin
          srcSsm[3:0] = codes[s];
          settle("R13");
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule